// File: doc/BRIEF.md
# Dual-Mode Bitstream Decimator

This block turns a one-bit comparator or modulator bitstream into a 16-bit running value that software reads over a small byte-wide register bus. A column selector picks one of several comparator columns. The chosen column supplies both the data bit and the sample strobe. Each strobe is one step of the running value.

The block has two modes. In the default mode, two integrators are cascaded: the first adds +1 for a one and -1 for a zero, the second accumulates the first, and the second one is the visible value. This is the front half of a delta-sigma decimation, and software does the rest of the filtering. In counter mode, a single accumulator counts the ones and serves an incremental converter. Each column can optionally be qualified by a window signal, so that ones are counted only while the conversion window is open.

A selectable timer line is brought through a two-flop synchroniser. Its rising edge, or its falling edge if so programmed, copies the running value into an output register, and the two data bytes read from that register. Writing either data byte, with any data, zeroes both integrators and the output register. The column strobe acts as a valid with no ready: every strobe is accepted in the cycle it is seen, so the source is never held back and must not rely on back-pressure.

Top module: `bitstream_decimator`

## Requirements
- R1: Address 0 reads bits 7:0 of the 16-bit output register and address 1 reads bits 15:8.
- R2: A write to address 0 or address 1 zeroes both integrators and the output register, whatever the write data.
- R3: Control register A (address 2) bits 1:0 select the column. Only that column's strobe and comparator bit affect the value, and strobes on other columns are ignored.
- R4: With control register B (address 3) bit 7 clear, each strobe adds +1 (bit 1) or -1 (bit 0) to the first integrator. The second integrator then adds the updated first integrator. The second integrator is the value, and both wrap modulo 2^16.
- R5: With control B bit 7 set, each strobe with bit 1 increments a single 16-bit counter, and the counter is the value.
- R6: In counter mode, if control A bit 4+c is set for the selected column c, a strobe is counted only while the window input is high.
- R7: Control B bits 1:0 select the timer line, which is synchronised by two flops. A rising edge copies the pre-update value into the output register, or a falling edge does so when control B bit 6 is set. Any other timer activity leaves the output register unchanged.
- R8: A data-byte write in the same cycle as a strobe or capture wins: the result is zero.
- R9: Control registers reset to zero. Reserved bits (A bits 3:2, B bits 5:2) read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_bits | input | 4 | Comparator bit per column |
| col_clk | input | 4 | Sample strobe per column |
| window | input | 1 | Conversion window for gating |
| timer_in | input | 4 | Candidate timer lines |

## Verification
Double-integrate mode is fed a mixed one/zero pattern and then a long run of zeros. The mixed pattern separates the cascaded sum from a single sum. The run of zeros forces a negative first integrator and makes the second one wrap past 2^16. Counter mode gets ones and zeros with the window both open and closed on a gated column, which shows whether the gate and the data bit each qualify the count. Strobes on unselected columns, edges on unselected timers, edges of the wrong polarity and a clear that coincides with a strobe each check that something has no effect or wins.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int DATA_W   = 16;
  localparam int NUM_COLS = 4;
  localparam int NUM_TMR  = 4;
  localparam int COL_W    = $clog2(NUM_COLS);
  localparam int TMR_W    = $clog2(NUM_TMR);

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTLA = 2'd2;
  localparam logic [1:0] ADDR_CTLB = 2'd3;

  typedef struct packed {
    logic [NUM_COLS-1:0] gate_en;
    logic [COL_W-1:0]    col_sel;
  } ctl_a_t;

  typedef struct packed {
    logic             count_mode;
    logic             fall_edge;
    logic [TMR_W-1:0] tmr_sel;
  } ctl_b_t;
endpackage

// File: rtl/dec_col_select.sv
module dec_col_select #(
  parameter int NUM_COLS = 4,
  localparam int COL_W = $clog2(NUM_COLS)
) (
  input  logic [NUM_COLS-1:0] cmp_bits,
  input  logic [NUM_COLS-1:0] col_clk,
  input  logic                window,
  input  logic [COL_W-1:0]    col_sel,
  input  logic [NUM_COLS-1:0] gate_en,
  input  logic                count_mode,
  output logic                step,
  output logic                data_bit
);
  logic gated;

  always_comb begin
    gated    = count_mode && gate_en[col_sel];
    data_bit = cmp_bits[col_sel];
    step     = col_clk[col_sel] && (!gated || window);
  end
endmodule

// File: rtl/dec_integrators.sv
module dec_integrators #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         step,
  input  logic         data_bit,
  input  logic         count_mode,
  output logic [W-1:0] value
);
  logic [W-1:0] acc1_q, acc2_q;
  logic [W-1:0] delta, acc1_next;

  always_comb begin
    delta     = data_bit ? W'(1) : {W{1'b1}};
    acc1_next = acc1_q + delta;
    value     = count_mode ? acc1_q : acc2_q;
  end

  // No reset: content is undefined until software clears it.
  always_ff @(posedge clk) begin
    if (clear) begin
      acc1_q <= '0;
      acc2_q <= '0;
    end else if (step) begin
      if (count_mode) begin
        if (data_bit) acc1_q <= acc1_q + W'(1);
      end else begin
        acc1_q <= acc1_next;
        acc2_q <= acc2_q + acc1_next;
      end
    end
  end
endmodule

// File: rtl/dec_snapshot.sv
module dec_snapshot #(
  parameter int W = 16,
  parameter int NUM_TMR = 4,
  localparam int TMR_W = $clog2(NUM_TMR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TMR-1:0] timer_in,
  input  logic [TMR_W-1:0]   tmr_sel,
  input  logic               fall_edge,
  input  logic               clear,
  input  logic [W-1:0]       value,
  output logic [W-1:0]       snap,
  output logic               capture
);
  logic [NUM_TMR-1:0] sync1_q, sync2_q;
  logic               prev_q, cur;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync1_q[t] <= 1'b0;
        sync2_q[t] <= 1'b0;
      end else begin
        sync1_q[t] <= timer_in[t];
        sync2_q[t] <= sync1_q[t];
      end
    end
  end

  always_comb begin
    cur     = sync2_q[tmr_sel];
    capture = fall_edge ? (prev_q && !cur) : (!prev_q && cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  always_ff @(posedge clk) begin
    if (clear)        snap <= '0;
    else if (capture) snap <= value;
  end
endmodule

// File: rtl/bitstream_decimator.sv
module bitstream_decimator
  import dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [3:0] cmp_bits,
  input  logic [3:0] col_clk,
  input  logic       window,
  input  logic [3:0] timer_in
);
  ctl_a_t            ctl_a_q;
  ctl_b_t            ctl_b_q;
  logic              clear_w, step_w, bit_w, capture_w;
  logic [DATA_W-1:0] value_w, snap_w;

  assign clear_w = bus_wr && (bus_addr == ADDR_LO || bus_addr == ADDR_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a_q <= '0;
      ctl_b_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_CTLA) begin
        ctl_a_q.gate_en <= bus_wdata[7:4];
        ctl_a_q.col_sel <= bus_wdata[COL_W-1:0];
      end
      if (bus_addr == ADDR_CTLB) begin
        ctl_b_q.count_mode <= bus_wdata[7];
        ctl_b_q.fall_edge  <= bus_wdata[6];
        ctl_b_q.tmr_sel    <= bus_wdata[TMR_W-1:0];
      end
    end
  end

  dec_col_select #(.NUM_COLS(NUM_COLS)) u_sel (
    .cmp_bits(cmp_bits), .col_clk(col_clk), .window(window),
    .col_sel(ctl_a_q.col_sel), .gate_en(ctl_a_q.gate_en),
    .count_mode(ctl_b_q.count_mode), .step(step_w), .data_bit(bit_w)
  );

  dec_integrators #(.W(DATA_W)) u_int (
    .clk(clk), .clear(clear_w), .step(step_w), .data_bit(bit_w),
    .count_mode(ctl_b_q.count_mode), .value(value_w)
  );

  dec_snapshot #(.W(DATA_W), .NUM_TMR(NUM_TMR)) u_snap (
    .clk(clk), .rst_n(rst_n), .timer_in(timer_in),
    .tmr_sel(ctl_b_q.tmr_sel), .fall_edge(ctl_b_q.fall_edge),
    .clear(clear_w), .value(value_w), .snap(snap_w), .capture(capture_w)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_LO:   bus_rdata = snap_w[7:0];
      ADDR_HI:   bus_rdata = snap_w[15:8];
      ADDR_CTLA: bus_rdata = {ctl_a_q.gate_en, 2'b00, ctl_a_q.col_sel};
      default:   bus_rdata = {ctl_b_q.count_mode, ctl_b_q.fall_edge, 4'b0000, ctl_b_q.tmr_sel};
    endcase
  end
endmodule

// File: rtl/dec_checker.sv
module dec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [7:0]  bus_rdata,
  input logic        step,
  input logic        data_bit,
  input logic        count_mode,
  input logic        capture,
  input logic [15:0] value,
  input logic [15:0] snap
);
  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[1]) |=> (value == 16'd0 && snap == 16'd0));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && count_mode && step && data_bit) |=> (value == $past(value) + 16'd1));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !step) |=> $stable(value));

  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !capture) |=> $stable(snap));

  a_r7_snap_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && capture) |=> (snap == $past(value)));

  a_r9_reserved_a: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> (bus_rdata[3:2] == 2'b00));

  a_r9_reserved_b: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata[5:2] == 4'b0000));
endmodule

bind bitstream_decimator dec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .step(step_w), .data_bit(bit_w),
  .count_mode(ctl_b_q.count_mode), .capture(capture_w),
  .value(value_w), .snap(snap_w)
);

// File: tb/sim_bitstream_decimator.sv
`timescale 1ns/1ps
module sim_bitstream_decimator;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [3:0] cmp_bits = '0, col_clk = '0, timer_in = '0;
  logic window = 1'b0;

  always #2 clk = ~clk;

  bitstream_decimator u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_bits(cmp_bits),
    .col_clk(col_clk), .window(window), .timer_in(timer_in)
  );

  typedef struct { logic [1:0] addr; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  logic mon_req = 1'b0;
  bit done = 1'b0;

  // reference model
  logic [15:0] m_i1 = '0, m_i2 = '0, m_snap = '0;
  logic m_mode = 0, m_fall = 0;
  logic [1:0] m_sel = 0, m_tsel = 0;
  logic [3:0] m_gate = 0;

  function automatic logic [15:0] m_val();
    return m_mode ? m_i1 : m_i2;
  endfunction

  always @(posedge clk) begin
    if (mon_req) begin
      item_t it;
      #1;
      it = q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: addr %0d actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
      end
    end
  end

  task automatic rd_check(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); bus_addr = a; mon_req = 1'b1;
    @(negedge clk); mon_req = 1'b0;
  endtask

  task automatic check_snap(input string tag);
    rd_check(2'd0, m_snap[7:0], tag);
    rd_check(2'd1, m_snap[15:8], tag);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    case (a)
      2'd0, 2'd1: begin m_i1 = '0; m_i2 = '0; m_snap = '0; end
      2'd2: begin m_gate = d[7:4]; m_sel = d[1:0]; end
      default: begin m_mode = d[7]; m_fall = d[6]; m_tsel = d[1:0]; end
    endcase
  endtask

  task automatic model_step(input int col, input bit b, input bit win);
    if (col == int'(m_sel)) begin
      if (m_mode) begin
        if (b && (!m_gate[col] || win)) m_i1 = m_i1 + 16'd1;
      end else begin
        m_i1 = m_i1 + (b ? 16'd1 : 16'hFFFF);
        m_i2 = m_i2 + m_i1;
      end
    end
  endtask

  task automatic step_col(input int col, input bit b, input bit win);
    @(negedge clk); col_clk = '0; col_clk[col] = 1'b1; cmp_bits[col] = b; window = win;
    model_step(col, b, win);
    @(negedge clk); col_clk = '0;
  endtask

  task automatic set_timer(input int idx, input bit lvl);
    @(negedge clk);
    if (idx == int'(m_tsel) && timer_in[idx] != lvl && lvl == !m_fall) m_snap = m_val();
    timer_in[idx] = lvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit pat[7] = '{1, 1, 0, 1, 1, 1, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_check(2'd2, 8'h00, "R9 reset ctl A");
    rd_check(2'd3, 8'h00, "R9 reset ctl B");

    bus_write(2'd0, 8'hA5);
    check_snap("R2 clear via low byte");

    // double integrate, mixed pattern
    foreach (pat[i]) step_col(0, pat[i], 0);
    set_timer(0, 1);
    check_snap("R4 R1 double mixed");

    // zeros: negative first integrator, second wraps
    for (int i = 0; i < 300; i++) step_col(0, 0, 0);
    set_timer(0, 0);
    check_snap("R7 falling edge ignored by default");
    set_timer(0, 1);
    check_snap("R4 wrap");
    set_timer(0, 0);

    bus_write(2'd1, 8'h3C);
    set_timer(0, 1);
    check_snap("R2 clear via high byte");
    set_timer(0, 0);

    // column select
    bus_write(2'd2, 8'h02);
    for (int i = 0; i < 5; i++) step_col(0, 1, 0);
    step_col(2, 1, 0); step_col(2, 1, 0); step_col(1, 0, 0);
    set_timer(0, 1);
    check_snap("R3 column select");
    set_timer(0, 0);

    // counter mode with gating on column 1
    bus_write(2'd3, 8'h80);
    bus_write(2'd2, 8'h21);
    bus_write(2'd0, 8'h00);
    step_col(1, 1, 1); step_col(1, 1, 0); step_col(1, 0, 1);
    step_col(1, 1, 1); step_col(1, 1, 0); step_col(1, 1, 1);
    set_timer(0, 1);
    check_snap("R6 R5 gated counter");
    set_timer(0, 0);
    bus_write(2'd2, 8'h01);
    for (int i = 0; i < 4; i++) step_col(1, 1, 0);
    step_col(1, 0, 0);
    set_timer(0, 1);
    check_snap("R5 ungated counter");
    set_timer(0, 0);

    // falling edge on timer 1
    bus_write(2'd3, 8'hC1);
    set_timer(1, 1);
    step_col(1, 1, 0);
    set_timer(0, 1);
    set_timer(0, 0);
    check_snap("R7 rise and other timer ignored");
    set_timer(1, 0);
    check_snap("R7 falling edge capture");

    // reserved bits
    bus_write(2'd2, 8'hFF);
    rd_check(2'd2, 8'hF3, "R9 reserved ctl A");
    bus_write(2'd3, 8'hFF);
    rd_check(2'd3, 8'hC3, "R9 reserved ctl B");

    // clear wins over a same-cycle strobe
    bus_write(2'd3, 8'h00);
    bus_write(2'd2, 8'h00);
    for (int i = 0; i < 3; i++) step_col(0, 1, 0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hFF;
    col_clk = 4'b0001; cmp_bits[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; col_clk = '0;
    m_i1 = '0; m_i2 = '0; m_snap = '0;
    step_col(0, 1, 0);
    set_timer(0, 1);
    check_snap("R8 clear beats step");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule